// File: doc/BRIEF.md
# Digitally Filtered PLL Lock Detector

This block decides whether a phase-locked loop is in lock by watching two pulse trains on a fast sampling clock. One train is the reference and the other is the divided feedback. Each train is cut down by a programmable edge prescaler, and one phase comparison is made per prescaler period. The comparison uses the leading edge of each divided signal. The gap between the two leading edges is counted in sampling-clock ticks, and it does not matter which edge comes first. The count saturates at its maximum value.

A digital filter with hysteresis turns the stream of measured gaps into a lock level. Lock is declared only after a run of consecutive small gaps, each below the lock window. Lock is withdrawn at once when a single gap lies above the unlock window. Both windows are inputs given in sampling ticks; a setting equivalent to about 10 ns is typical. An enable input forces the reported level low without disturbing the filter's internal state.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset, `lock_det` is 0 and the lock filter holds no count of small errors.
- R2: A rising edge on `ref_in` or `fb_in` is counted as one edge. Per input, only the first rising edge of every group of `DIV` edges takes part in a comparison; all other edges have no effect on `lock_det`.
- R3: The phase error is the number of sampling-clock cycles between the two counted leading edges, whichever input leads. Edges in the same cycle give an error of 0.
- R4: The error saturates at 2^`CNT_W`-1. A larger gap is reported as exactly that value, and the count never wraps to a small value.
- R5: `lock_det` rises only after `LOCK_RUN` consecutive comparisons whose error is strictly less than `lock_win`.
- R6: A single comparison whose error is strictly greater than `unlock_win` clears the lock and clears the run of small errors.
- R7: An error in the band `lock_win` <= error <= `unlock_win` leaves the current lock state unchanged. It restarts the run of small errors from zero.
- R8: While `lock_en` is 0, `lock_det` is 0. The filter keeps updating during that time, so raising `lock_en` again shows the current filter state at once.
- R9: The boundaries are exclusive. An error equal to `lock_win` does not count as small, and an error equal to `unlock_win` does not count as large.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | 1 = report lock, 0 = force `lock_det` low |
| lock_win | input | CNT_W | Lock window in ticks; errors below it count as small |
| unlock_win | input | CNT_W | Unlock window in ticks; errors above it drop lock |
| ref_in | input | 1 | Reference pulse train, synchronous to `clk` |
| fb_in | input | 1 | Divided feedback pulse train, synchronous to `clk` |
| lock_det | output | 1 | Lock-detect level |

## Verification
The bench builds the block with `DIV`=4, `CNT_W`=4 and `LOCK_RUN`=4. With these values a full comparison period lasts only a few hundred cycles, and saturation happens at 15 ticks. This makes it cheap to sweep every gap from 0 to 16 in both lead directions under two window settings. Each value is checked against an arithmetic model of the filter after every comparison. Large gaps are placed on the non-leading pulse pairs of every group, to show that they are ignored. Dedicated sequences cover saturation against an unlock window at its maximum value, the in-band streak reset, and the enable gate.

// File: rtl/lkdet_pkg.sv
package lkdet_pkg;

    localparam int unsigned LKD_MAX_W = 16;

    typedef enum logic [1:0] {
        GAP_IDLE      = 2'd0,
        GAP_REF_FIRST = 2'd1,
        GAP_FB_FIRST  = 2'd2
    } gap_state_e;

    typedef enum logic [1:0] {
        VERD_SMALL = 2'd0,
        VERD_MID   = 2'd1,
        VERD_LARGE = 2'd2
    } verdict_e;

    typedef struct packed {
        logic                 vld;
        logic [LKD_MAX_W-1:0] err;
    } gap_meas_t;

    function automatic verdict_e classify_gap(
        input logic [LKD_MAX_W-1:0] err,
        input logic [LKD_MAX_W-1:0] win_lo,
        input logic [LKD_MAX_W-1:0] win_hi
    );
        if (err > win_hi)
            return VERD_LARGE;
        else if (err < win_lo)
            return VERD_SMALL;
        else
            return VERD_MID;
    endfunction

endpackage

// File: rtl/lkdet_edge_prescaler.sv
module lkdet_edge_prescaler #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_i,
    output logic mark_o
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic             prev_q;
    logic             rise;
    logic [DIV_W-1:0] ecnt_q;

    assign rise = pulse_i & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            ecnt_q <= '0;
            mark_o <= 1'b0;
        end else begin
            prev_q <= pulse_i;
            mark_o <= rise && (ecnt_q == '0);
            if (rise)
                ecnt_q <= (ecnt_q == LAST) ? '0 : ecnt_q + 1'b1;
        end
    end

    // R2: a leading mark only follows a real rising edge
    a_r2_mark_from_edge: assert property (@(posedge clk) disable iff (rst)
        mark_o |-> $past(rise));

endmodule

// File: rtl/lkdet_gap_meter.sv
module lkdet_gap_meter
    import lkdet_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mark_ref,
    input  logic             mark_fb,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_err
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    gap_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next_sat;

    assign cnt_next_sat = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= GAP_IDLE;
            cnt_q    <= '0;
            meas_vld <= 1'b0;
            meas_err <= '0;
        end else begin
            meas_vld <= 1'b0;
            unique case (st_q)
                GAP_IDLE: begin
                    if (mark_ref && mark_fb) begin
                        meas_vld <= 1'b1;
                        meas_err <= '0;
                    end else if (mark_ref) begin
                        st_q  <= GAP_REF_FIRST;
                        cnt_q <= CNT_W'(1);
                    end else if (mark_fb) begin
                        st_q  <= GAP_FB_FIRST;
                        cnt_q <= CNT_W'(1);
                    end
                end
                GAP_REF_FIRST: begin
                    if (mark_fb) begin
                        meas_vld <= 1'b1;
                        meas_err <= cnt_q;
                        st_q     <= GAP_IDLE;
                    end else if (mark_ref) begin
                        cnt_q <= CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_next_sat;
                    end
                end
                GAP_FB_FIRST: begin
                    if (mark_ref) begin
                        meas_vld <= 1'b1;
                        meas_err <= cnt_q;
                        st_q     <= GAP_IDLE;
                    end else if (mark_fb) begin
                        cnt_q <= CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_next_sat;
                    end
                end
                default: st_q <= GAP_IDLE;
            endcase
        end
    end

    // R4: a saturated count that keeps waiting stays saturated
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (st_q != GAP_IDLE && cnt_q == CNT_MAX && !mark_ref && !mark_fb)
        |=> (cnt_q == CNT_MAX));

    // R3: two coincident leading marks from idle report a zero error
    a_r3_coincident_zero: assert property (@(posedge clk) disable iff (rst)
        (st_q == GAP_IDLE && mark_ref && mark_fb) |=> (meas_vld && meas_err == '0));

endmodule

// File: rtl/lkdet_lock_filter.sv
module lkdet_lock_filter
    import lkdet_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_vld,
    input  logic [CNT_W-1:0] meas_err,
    input  logic [CNT_W-1:0] lock_win,
    input  logic [CNT_W-1:0] unlock_win,
    output logic             locked
);
    localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);

    logic [RUN_W-1:0] run_q;
    logic             lock_q;
    verdict_e         verd;

    assign verd = classify_gap(LKD_MAX_W'(meas_err), LKD_MAX_W'(lock_win),
                               LKD_MAX_W'(unlock_win));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            lock_q <= 1'b0;
        end else if (meas_vld) begin
            unique case (verd)
                VERD_LARGE: begin
                    run_q  <= '0;
                    lock_q <= 1'b0;
                end
                VERD_SMALL: begin
                    if (run_q < RUN_TOP)
                        run_q <= run_q + 1'b1;
                    if (run_q + 1'b1 >= RUN_TOP)
                        lock_q <= 1'b1;
                end
                default: run_q <= '0;
            endcase
        end
    end

    assign locked = lock_q;

    // R1: reset leaves the filter unlocked with an empty run
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!lock_q && run_q == '0));

    // R6: one large error drops lock in the next cycle
    a_r6_large_unlocks: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && meas_err > unlock_win) |=> !lock_q);

    // R5: lock only rises on a small-error comparison
    a_r5_rise_on_small: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(meas_vld && meas_err < lock_win));

    // R7: an in-band error keeps the lock state
    a_r7_band_holds: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && meas_err >= lock_win && meas_err <= unlock_win)
        |=> (lock_q == $past(lock_q)));

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
    parameter int unsigned DIV      = 64,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_en,
    input  logic [CNT_W-1:0] lock_win,
    input  logic [CNT_W-1:0] unlock_win,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic             lock_det
);
    localparam int unsigned N_STREAMS = 2;

    logic [N_STREAMS-1:0] pulses;
    logic [N_STREAMS-1:0] marks;
    logic                 meas_vld;
    logic [CNT_W-1:0]     meas_err;
    logic                 locked;

    assign pulses = {fb_in, ref_in};

    for (genvar s = 0; s < N_STREAMS; s++) begin : g_pre
        lkdet_edge_prescaler #(.DIV(DIV)) u_pre (
            .clk     (clk),
            .rst     (rst),
            .pulse_i (pulses[s]),
            .mark_o  (marks[s])
        );
    end

    lkdet_gap_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .mark_ref (marks[0]),
        .mark_fb  (marks[1]),
        .meas_vld (meas_vld),
        .meas_err (meas_err)
    );

    lkdet_lock_filter #(.CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_filt (
        .clk        (clk),
        .rst        (rst),
        .meas_vld   (meas_vld),
        .meas_err   (meas_err),
        .lock_win   (lock_win),
        .unlock_win (unlock_win),
        .locked     (locked)
    );

    assign lock_det = locked & lock_en;

    // R8: filter state reappears on the output while enabled
    a_r8_gate_transparent: assert property (@(posedge clk) disable iff (rst)
        (lock_en && $stable(locked)) |-> (lock_det == locked));

endmodule

// File: tb/pll_lock_monitor_bench.sv
module pll_lock_monitor_bench;
    localparam int unsigned DIV      = 4;
    localparam int unsigned CNT_W    = 4;
    localparam int unsigned LOCK_RUN = 4;
    localparam int unsigned PER      = 40;
    localparam int unsigned SATV     = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lock_en = 1'b1;
    logic [CNT_W-1:0] lock_win = 4'd4;
    logic [CNT_W-1:0] unlock_win = 4'd9;
    logic             ref_in = 1'b0;
    logic             fb_in = 1'b0;
    logic             lock_det;

    int n_vec = 0;
    int n_bad = 0;
    int m_run = 0;
    bit m_lock = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pll_lock_monitor #(.DIV(DIV), .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_pll_lock_monitor (
        .clk        (clk),
        .rst        (rst),
        .lock_en    (lock_en),
        .lock_win   (lock_win),
        .unlock_win (unlock_win),
        .ref_in     (ref_in),
        .fb_in      (fb_in),
        .lock_det   (lock_det)
    );

    task automatic check(input string req, input bit got, input bit exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_det=%0d expected=%0d (lw=%0d uw=%0d)",
                     req, got, exp, lock_win, unlock_win);
        end
    endtask

    // model of the filter for one comparison with gap off
    task automatic model_step(input int off);
        int e;
        e = (off > SATV) ? SATV : off;
        if (e > int'(unlock_win)) begin
            m_run = 0; m_lock = 1'b0;
        end else if (e < int'(lock_win)) begin
            m_run++;
            if (m_run >= LOCK_RUN) m_lock = 1'b1;
        end else begin
            m_run = 0;
        end
    endtask

    // one comparison group: leading pair with gap off, later pairs with gap tail
    task automatic do_cmp(input bit lead_ref, input int off, input int tail);
        for (int k = 0; k < DIV; k++) begin
            int o;
            o = (k == 0) ? off : tail;
            for (int c = 0; c < PER; c++) begin
                @(negedge clk);
                ref_in = lead_ref ? (c == 0) : (c == o);
                fb_in  = lead_ref ? (c == o) : (c == 0);
            end
        end
        @(negedge clk);
        ref_in = 1'b0;
        fb_in  = 1'b0;
        model_step(off);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", lock_det, 1'b0);

        // R3 R5 R6 R7 R9 R2: sweep gaps and lead directions under two window pairs
        for (int w = 0; w < 2; w++) begin
            lock_win   = (w == 0) ? 4'd4 : 4'd7;
            unlock_win = (w == 0) ? 4'd9 : 4'd14;
            for (int off = 0; off <= 16; off++) begin
                for (int ld = 0; ld < 2; ld++) begin
                    do_cmp(1'b1, 30, 30);
                    check("R6 prime unlock", lock_det, m_lock);
                    for (int r = 0; r < 5; r++) begin
                        do_cmp(ld[0], off, 30);
                        check(off == int'(lock_win) || off == int'(unlock_win) ?
                              "R9 boundary" : "R3 R5 R2 sweep", lock_det, m_lock);
                    end
                end
            end
        end

        // R7: in-band error keeps lock, restarts the run
        lock_win = 4'd4; unlock_win = 4'd9;
        for (int r = 0; r < 4; r++) do_cmp(1'b1, 1, 30);
        check("R5 locked", lock_det, 1'b1);
        do_cmp(1'b0, 6, 30);
        check("R7 band holds lock", lock_det, m_lock);
        do_cmp(1'b1, 30, 0);
        check("R6 unlock", lock_det, 1'b0);
        for (int r = 0; r < 3; r++) do_cmp(1'b1, 2, 30);
        do_cmp(1'b1, 5, 30);
        do_cmp(1'b1, 2, 30);
        check("R7 run restarted", lock_det, 1'b0);
        for (int r = 0; r < 3; r++) do_cmp(1'b1, 2, 30);
        check("R7 run complete", lock_det, 1'b1);

        // R4: saturation to 15 against unlock window at max and below
        unlock_win = 4'd15;
        do_cmp(1'b1, 30, 30);
        check("R4 sat not above 15", lock_det, m_lock);
        do_cmp(1'b0, 25, 30);
        check("R4 sat other lead", lock_det, m_lock);
        unlock_win = 4'd14;
        do_cmp(1'b0, 30, 30);
        check("R4 sat above 14", lock_det, 1'b0);

        // R8: enable gate
        unlock_win = 4'd9;
        for (int r = 0; r < 4; r++) do_cmp(1'b1, 0, 30);
        check("R8 locked before gate", lock_det, 1'b1);
        lock_en = 1'b0;
        @(negedge clk);
        check("R8 forced low", lock_det, 1'b0);
        do_cmp(1'b1, 30, 30);
        for (int r = 0; r < 4; r++) do_cmp(1'b1, 1, 30);
        check("R8 low while filter relocks", lock_det, 1'b0);
        lock_en = 1'b1;
        @(negedge clk);
        check("R8 restored", lock_det, m_lock);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule